// File: doc/BRIEF.md
# Cross Trigger Interface Unit

This block routes hardware trigger events between one component and a small set of shared event channels. Each input trigger may be mapped onto any of the channels. Each output trigger may be mapped onto any of the channels. A channel becomes active when a mapped input trigger fires, when software sets it, when software pulses it, or when the external channel matrix sends it back in. Any output trigger mapped to an active channel is driven.

Locally active channels are sent out to the external matrix through a per-channel propagation gate. A safety filter can mask chosen output triggers so that they can never assert while the filter is on. A global enable forces every output quiet. A single command returns all routing and all controls to their reset values.

A simple register port with a single-cycle write strobe and a combinational read gives software access to the mappings, the channel controls, the gate, the filter and the status.

Top module: `xtrig_unit`

## Requirements
- R1: After reset the following hold. Every mapping register reads 0. The gate reads 0xF. The filter enable reads 1. The filter mask reads 0x01. The enable reads 0. Every output reads 0. With the unit enabled but nothing mapped, no trigger or channel activity reaches any output.
- R2: A channel is active when any input trigger whose mapping register has that channel's bit set is high. An output trigger goes high when its mapping register has a bit set for an active channel. The output appears on `trig_out` after one rising clock edge.
- R3: A channel arriving on `ch_from_mtx` drives the output triggers mapped to it, with the same one-edge latency. It does not appear in the channel status and does not appear on `ch_to_mtx`.
- R4: `ch_to_mtx[c]` is high only when channel c is locally active and gate bit c is 1.
- R5: Writing ones to SET (0x01) holds those channels active until ones are written to CLR (0x02) for the same bits. The outputs follow one edge after the write edge. After a clear, both the channel status and the dependent output triggers return to 0.
- R6: Writing ones to PULSE (0x03) makes those channels active for exactly one clock cycle, which shows on the outputs one edge after the write edge.
- R7: While FEN (0x05) bit 0 is 1, no output trigger whose bit is set in FMASK (0x06) is ever driven high. When FEN bit 0 is 0, those outputs behave normally.
- R8: While CTRL (0x00) bit 0 (the enable) is 0, `trig_out`, `ch_to_mtx` and the channel status are all 0. Mapping and gate registers keep their programmed values while the unit is disabled.
- R9: A write to CTRL with bit 1 set returns every mapping, the gate, FEN, FMASK, the held channels and the enable to their reset values.
- R10: The register map is as follows. GATE is at 0x04. Channel status (read-only) is at 0x07, with bit c meaning channel c is active. Output-trigger status is at 0x08, with bit o meaning output o is high. Input status is at 0x09. The input mapping for trigger i is at 0x10+i and the output mapping for trigger o is at 0x20+o, with bit c selecting channel c. As an example, with channel 2 set, the channel status reads 0x4 and an output 6 mapped to it reads 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_IN | Hardware input triggers |
| trig_out | output | N_OUT | Hardware output triggers, registered |
| ch_from_mtx | input | N_CH | Channel events arriving from the matrix |
| ch_to_mtx | output | N_CH | Gated channel events sent to the matrix, registered |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from address |

## Verification
The results arrive at different times. A change on `trig_in` or `ch_from_mtx` is captured at the next rising edge and shows on `trig_out`, `ch_to_mtx` and the channel status just after that edge. A register write takes effect at its own edge, so a set, clear, pulse or enable change shows on the outputs one edge later. A pulse must be seen high after that edge and low after the following one. Reads are combinational. The bench therefore does the following: it drives inputs on the falling edge, samples outputs 2 ns after the next rising edge, and compares them against a model that uses the inputs and register state in force before that edge.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
   localparam int AW = 6;
   localparam logic [AW-1:0] A_CTRL   = 6'h00;
   localparam logic [AW-1:0] A_SET    = 6'h01;
   localparam logic [AW-1:0] A_CLR    = 6'h02;
   localparam logic [AW-1:0] A_PULSE  = 6'h03;
   localparam logic [AW-1:0] A_GATE   = 6'h04;
   localparam logic [AW-1:0] A_FEN    = 6'h05;
   localparam logic [AW-1:0] A_FMASK  = 6'h06;
   localparam logic [AW-1:0] A_CHST   = 6'h07;
   localparam logic [AW-1:0] A_TOST   = 6'h08;
   localparam logic [AW-1:0] A_TIST   = 6'h09;
   localparam int IN_BASE  = 16;
   localparam int OUT_BASE = 32;
   localparam int MAP_SPAN = 16;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_RST_BIT = 1;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
   import xtrig_pkg::*;
#(
   parameter int N_IN  = 8,
   parameter int N_OUT = 8,
   parameter int N_CH  = 4,
   parameter int DW    = 32,
   parameter logic [N_OUT-1:0] FMASK_RST = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [AW-1:0]         addr,
   input  logic [DW-1:0]         wdata,
   input  logic [N_CH-1:0]       ch_stat,
   input  logic [N_OUT-1:0]      to_stat,
   input  logic [N_IN-1:0]       ti_stat,
   output logic [DW-1:0]         rdata,
   output logic                  en,
   output logic [N_IN*N_CH-1:0]  in_map,
   output logic [N_OUT*N_CH-1:0] out_map,
   output logic [N_CH-1:0]       gate,
   output logic                  filt_en,
   output logic [N_OUT-1:0]      filt_mask,
   output logic [N_CH-1:0]       sw_hold,
   output logic [N_CH-1:0]       sw_pulse
);
   logic                rst_prog;
   logic [N_CH-1:0]     wch;

   assign rst_prog = wr && (addr == A_CTRL) && wdata[CTRL_RST_BIT];
   assign wch      = wdata[N_CH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         gate      <= '1;
         filt_en   <= 1'b1;
         filt_mask <= FMASK_RST;
         sw_hold   <= '0;
      end else if (rst_prog) begin
         en        <= 1'b0;
         gate      <= '1;
         filt_en   <= 1'b1;
         filt_mask <= FMASK_RST;
         sw_hold   <= '0;
      end else if (wr) begin
         case (addr)
            A_CTRL:  en        <= wdata[CTRL_EN_BIT];
            A_SET:   sw_hold   <= sw_hold | wch;
            A_CLR:   sw_hold   <= sw_hold & ~wch;
            A_GATE:  gate      <= wch;
            A_FEN:   filt_en   <= wdata[0];
            A_FMASK: filt_mask <= wdata[N_OUT-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sw_pulse <= '0;
      else if (wr && (addr == A_PULSE))
         sw_pulse <= wch;
      else
         sw_pulse <= '0;
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_in_map
      localparam logic [AW-1:0] MY_A = AW'(IN_BASE + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            in_map[i*N_CH +: N_CH] <= '0;
         else if (rst_prog)
            in_map[i*N_CH +: N_CH] <= '0;
         else if (wr && (addr == MY_A))
            in_map[i*N_CH +: N_CH] <= wch;
      end
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_out_map
      localparam logic [AW-1:0] MY_A = AW'(OUT_BASE + o);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            out_map[o*N_CH +: N_CH] <= '0;
         else if (rst_prog)
            out_map[o*N_CH +: N_CH] <= '0;
         else if (wr && (addr == MY_A))
            out_map[o*N_CH +: N_CH] <= wch;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:  rdata = DW'(en);
         A_GATE:  rdata = DW'(gate);
         A_FEN:   rdata = DW'(filt_en);
         A_FMASK: rdata = DW'(filt_mask);
         A_CHST:  rdata = DW'(ch_stat);
         A_TOST:  rdata = DW'(to_stat);
         A_TIST:  rdata = DW'(ti_stat);
         default: begin
            for (int i = 0; i < N_IN; i++)
               if (addr == AW'(IN_BASE + i))
                  rdata = DW'(in_map[i*N_CH +: N_CH]);
            for (int o = 0; o < N_OUT; o++)
               if (addr == AW'(OUT_BASE + o))
                  rdata = DW'(out_map[o*N_CH +: N_CH]);
         end
      endcase
   end
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
   parameter int N_IN  = 8,
   parameter int N_OUT = 8,
   parameter int N_CH  = 4
) (
   input  logic [N_IN-1:0]       trig_in,
   input  logic [N_IN*N_CH-1:0]  in_map,
   input  logic [N_OUT*N_CH-1:0] out_map,
   input  logic [N_CH-1:0]       sw_hold,
   input  logic [N_CH-1:0]       sw_pulse,
   input  logic [N_CH-1:0]       ch_from_mtx,
   output logic [N_CH-1:0]       chan_local,
   output logic [N_OUT-1:0]      trig_raw
);
   logic [N_IN-1:0] in_col [N_CH];
   logic [N_CH-1:0] chan_all;

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      for (genvar i = 0; i < N_IN; i++) begin : g_col
         assign in_col[c][i] = in_map[i*N_CH + c];
      end
      assign chan_local[c] = (|(trig_in & in_col[c])) | sw_hold[c] | sw_pulse[c];
   end

   assign chan_all = chan_local | ch_from_mtx;

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      assign trig_raw[o] = |(chan_all & out_map[o*N_CH +: N_CH]);
   end
endmodule

// File: rtl/xtrig_outstage.sv
module xtrig_outstage #(
   parameter int N_OUT = 8,
   parameter int N_CH  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [N_CH-1:0]  gate,
   input  logic             filt_en,
   input  logic [N_OUT-1:0] filt_mask,
   input  logic [N_CH-1:0]  chan_local,
   input  logic [N_OUT-1:0] trig_raw,
   output logic [N_OUT-1:0] trig_out,
   output logic [N_CH-1:0]  ch_to_mtx,
   output logic [N_CH-1:0]  ch_stat
);
   logic [N_OUT-1:0] blocked;
   assign blocked = filt_en ? filt_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_out  <= '0;
         ch_to_mtx <= '0;
         ch_stat   <= '0;
      end else if (!en) begin
         trig_out  <= '0;
         ch_to_mtx <= '0;
         ch_stat   <= '0;
      end else begin
         trig_out  <= trig_raw & ~blocked;
         ch_to_mtx <= chan_local & gate;
         ch_stat   <= chan_local;
      end
   end
endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit
   import xtrig_pkg::*;
#(
   parameter int N_IN  = 8,
   parameter int N_OUT = 8,
   parameter int N_CH  = 4,
   parameter int DW    = 32,
   parameter logic [N_OUT-1:0] FMASK_RST = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  trig_in,
   output logic [N_OUT-1:0] trig_out,
   input  logic [N_CH-1:0]  ch_from_mtx,
   output logic [N_CH-1:0]  ch_to_mtx,
   input  logic             reg_wr,
   input  logic [AW-1:0]    reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata
);
   if (N_CH < 1 || N_CH > DW) begin : g_bad_ch
      $error("xtrig_unit: N_CH must lie in 1..DW");
   end
   if (N_IN < 1 || N_IN > MAP_SPAN || N_IN > DW) begin : g_bad_in
      $error("xtrig_unit: N_IN out of range");
   end
   if (N_OUT < 1 || N_OUT > MAP_SPAN || N_OUT > DW) begin : g_bad_out
      $error("xtrig_unit: N_OUT out of range");
   end

   logic                  en_q;
   logic [N_IN*N_CH-1:0]  in_map;
   logic [N_OUT*N_CH-1:0] out_map;
   logic [N_CH-1:0]       gate_q;
   logic                  filt_en_q;
   logic [N_OUT-1:0]      filt_mask_q;
   logic [N_CH-1:0]       sw_hold;
   logic [N_CH-1:0]       sw_pulse;
   logic [N_CH-1:0]       chan_local;
   logic [N_OUT-1:0]      trig_raw;
   logic [N_CH-1:0]       ch_stat;

   xtrig_regs #(
      .N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH), .DW(DW), .FMASK_RST(FMASK_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .ch_stat(ch_stat), .to_stat(trig_out), .ti_stat(trig_in), .rdata(reg_rdata),
      .en(en_q), .in_map(in_map), .out_map(out_map), .gate(gate_q),
      .filt_en(filt_en_q), .filt_mask(filt_mask_q),
      .sw_hold(sw_hold), .sw_pulse(sw_pulse)
   );

   xtrig_route #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH)) u_route (
      .trig_in(trig_in), .in_map(in_map), .out_map(out_map),
      .sw_hold(sw_hold), .sw_pulse(sw_pulse), .ch_from_mtx(ch_from_mtx),
      .chan_local(chan_local), .trig_raw(trig_raw)
   );

   xtrig_outstage #(.N_OUT(N_OUT), .N_CH(N_CH)) u_out (
      .clk(clk), .rst_n(rst_n), .en(en_q), .gate(gate_q),
      .filt_en(filt_en_q), .filt_mask(filt_mask_q),
      .chan_local(chan_local), .trig_raw(trig_raw),
      .trig_out(trig_out), .ch_to_mtx(ch_to_mtx), .ch_stat(ch_stat)
   );
endmodule

// File: rtl/xtrig_unit_chk.sv
module xtrig_unit_chk
   import xtrig_pkg::*;
#(
   parameter int N_IN  = 8,
   parameter int N_OUT = 8,
   parameter int N_CH  = 4,
   parameter int DW    = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr,
   input logic [AW-1:0]         reg_addr,
   input logic [DW-1:0]         reg_wdata,
   input logic                  en,
   input logic [N_CH-1:0]       gate,
   input logic                  filt_en,
   input logic [N_OUT-1:0]      filt_mask,
   input logic [N_IN*N_CH-1:0]  in_map,
   input logic [N_OUT*N_CH-1:0] out_map,
   input logic [N_OUT-1:0]      trig_out,
   input logic [N_CH-1:0]       ch_to_mtx,
   input logic [N_CH-1:0]       ch_stat
);
   assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (trig_out == '0 && ch_to_mtx == '0 && ch_stat == '0));

   assert_filter_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      filt_en |=> ((trig_out & $past(filt_mask)) == '0));

   assert_gate_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ((ch_to_mtx & ~$past(gate)) == '0));

   assert_gate_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_to_mtx & ~ch_stat) == '0);

   assert_reset_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_RST_BIT]) |=>
      (gate == '1 && in_map == '0 && out_map == '0 && filt_en && !en));
endmodule

bind xtrig_unit xtrig_unit_chk #(
   .N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .en(en_q), .gate(gate_q), .filt_en(filt_en_q),
   .filt_mask(filt_mask_q), .in_map(in_map), .out_map(out_map),
   .trig_out(trig_out), .ch_to_mtx(ch_to_mtx), .ch_stat(ch_stat)
);

// File: tb/xtrig_unit_tb.sv
module xtrig_unit_tb;
   import xtrig_pkg::*;
   localparam int NI = 8, NO = 8, NC = 4, DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] trig_in = '0;
   logic [NO-1:0] trig_out;
   logic [NC-1:0] ch_from_mtx = '0;
   logic [NC-1:0] ch_to_mtx;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;

   int total = 0, bad = 0;
   bit done = 1'b0;

   logic [NC-1:0] m_in [NI];
   logic [NC-1:0] m_out [NO];
   logic [NC-1:0] m_gate, m_hold;
   logic          m_fen, m_en;
   logic [NO-1:0] m_fmask;

   always #4 clk = ~clk;

   xtrig_unit u_dut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
      .ch_from_mtx(ch_from_mtx), .ch_to_mtx(ch_to_mtx), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [NC-1:0] f_chan(logic [NI-1:0] ti, logic [NC-1:0] sw);
      logic [NC-1:0] c = sw;
      for (int i = 0; i < NI; i++) if (ti[i]) c |= m_in[i];
      return c;
   endfunction

   function automatic logic [NO-1:0] f_tout(logic [NI-1:0] ti, logic [NC-1:0] fm,
                                            logic [NC-1:0] sw);
      logic [NC-1:0] all = f_chan(ti, sw) | fm;
      logic [NO-1:0] t = '0;
      for (int o = 0; o < NO; o++) t[o] = |(all & m_out[o]);
      if (m_fen) t &= ~m_fmask;
      return m_en ? t : '0;
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic model_defaults();
      for (int i = 0; i < NI; i++) m_in[i] = '0;
      for (int o = 0; o < NO; o++) m_out[o] = '0;
      m_gate = '1; m_hold = '0; m_fen = 1'b1; m_en = 1'b0; m_fmask = 8'h01;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
      if (a == A_CTRL && d[CTRL_RST_BIT]) model_defaults();
      else if (a == A_CTRL) m_en = d[0];
      else if (a == A_SET) m_hold |= d[NC-1:0];
      else if (a == A_CLR) m_hold &= ~d[NC-1:0];
      else if (a == A_GATE) m_gate = d[NC-1:0];
      else if (a == A_FEN) m_fen = d[0];
      else if (a == A_FMASK) m_fmask = d[NO-1:0];
      else if (a >= AW'(IN_BASE) && a < AW'(IN_BASE + NI)) m_in[a - AW'(IN_BASE)] = d[NC-1:0];
      else if (a >= AW'(OUT_BASE) && a < AW'(OUT_BASE + NO)) m_out[a - AW'(OUT_BASE)] = d[NC-1:0];
   endtask

   task automatic rd(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 check(tag, reg_rdata, exp);
   endtask

   // drive inputs, then check every output just after the next rising edge
   task automatic step(string tag, logic [NI-1:0] ti, logic [NC-1:0] fm, logic [NC-1:0] pulse);
      logic [NC-1:0] ch;
      @(negedge clk);
      trig_in = ti; ch_from_mtx = fm; reg_addr = A_CHST;
      ch = m_en ? f_chan(ti, m_hold | pulse) : '0;
      @(posedge clk);
      #2;
      check({tag, " trig_out"}, DW'(trig_out), DW'(f_tout(ti, fm, m_hold | pulse)));
      check({tag, " ch_to_mtx"}, DW'(ch_to_mtx), DW'(ch & m_gate));
      check({tag, " ch_status"}, reg_rdata, DW'(ch));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_defaults();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset defaults
      check("R1 trig_out", DW'(trig_out), 0);
      check("R1 ch_to_mtx", DW'(ch_to_mtx), 0);
      rd("R1 gate", A_GATE, 32'hF);
      rd("R1 fen", A_FEN, 1);
      rd("R1 fmask", A_FMASK, 32'h01);
      rd("R1 ctrl", A_CTRL, 0);
      rd("R1 inmap3", AW'(IN_BASE + 3), 0);
      rd("R1 outmap5", AW'(OUT_BASE + 5), 0);
      wr(A_CTRL, 1);
      step("R1 unmapped", 8'hFF, 4'hF, 4'h0);

      // R2 R3 R4 R10: random routing against the model
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < NI; i++) wr(AW'(IN_BASE + i), DW'($urandom & 32'hF));
         for (int o = 0; o < NO; o++) wr(AW'(OUT_BASE + o), DW'($urandom & 32'hF));
         wr(A_GATE, DW'($urandom & 32'hF));
         wr(A_FMASK, DW'($urandom & 32'hFF));
         wr(A_FEN, DW'(r % 2));
         for (int k = 0; k < 60; k++)
            step("R2 R3 R4 random", NI'($urandom), NC'($urandom), 4'h0);
      end
      rd("R10 trig in status", A_TIST, DW'(trig_in));

      // R3: inbound channel alone reaches outputs but not local status
      wr(A_CTRL, 32'h2); wr(A_CTRL, 1); wr(A_FEN, 0);
      wr(AW'(OUT_BASE + 4), 32'h8);
      step("R3 inbound ch3", 8'h00, 4'h8, 4'h0);
      check("R3 out4", DW'(trig_out), 32'h10);

      // R5 R10: set / clear channel 2
      wr(AW'(IN_BASE + 1), 32'h4);
      wr(AW'(OUT_BASE + 6), 32'h4);
      wr(A_SET, 32'h4);
      step("R5 set", 8'h00, 4'h0, 4'h0);
      rd("R10 chst", A_CHST, 32'h4);
      rd("R10 tost", A_TOST, 32'h40);
      step("R5 held", 8'h00, 4'h0, 4'h0);
      check("R5 still high", DW'(trig_out[6]), 1);
      wr(A_CLR, 32'h4);
      step("R5 cleared", 8'h00, 4'h0, 4'h0);
      rd("R5 chst zero", A_CHST, 0);
      rd("R5 tost zero", A_TOST, 0);

      // R6: pulse lasts exactly one cycle
      wr(A_PULSE, 32'h4);
      step("R6 pulse high", 8'h00, 4'h0, 4'h4);
      check("R6 out6 high", DW'(trig_out[6]), 1);
      step("R6 pulse low", 8'h00, 4'h0, 4'h0);
      check("R6 out6 low", DW'(trig_out[6]), 0);

      // R7: filter masks output 6
      wr(A_FMASK, 32'h40); wr(A_FEN, 1);
      step("R7 filtered", 8'h02, 4'h0, 4'h0);
      check("R7 out6 blocked", DW'(trig_out), 0);
      wr(A_FEN, 0);
      step("R7 unfiltered", 8'h02, 4'h0, 4'h0);
      check("R7 out6 passes", DW'(trig_out), 32'h40);

      // R8: disable forces quiet, mappings kept
      wr(A_SET, 32'hF);
      wr(A_CTRL, 0);
      step("R8 disabled", 8'hFF, 4'hF, 4'h0);
      check("R8 out zero", DW'(trig_out), 0);
      rd("R8 inmap kept", AW'(IN_BASE + 1), 32'h4);
      rd("R8 gate kept", A_GATE, DW'(m_gate));

      // R9: reset-programming command
      wr(A_CTRL, 32'h2);
      rd("R9 inmap1", AW'(IN_BASE + 1), 0);
      rd("R9 outmap6", AW'(OUT_BASE + 6), 0);
      rd("R9 gate", A_GATE, 32'hF);
      rd("R9 fen", A_FEN, 1);
      rd("R9 fmask", A_FMASK, 32'h01);
      rd("R9 ctrl", A_CTRL, 0);
      wr(A_CTRL, 1);
      step("R9 inert", 8'hFF, 4'hF, 4'h0);
      check("R9 no outputs", DW'(trig_out), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule